// File: doc/BRIEF.md
# ROM Checksum and Socket-Presence Scanner

The block walks five fixed-size ROM regions through a synchronous byte-read port. Each byte is read exactly once. For every region it keeps two running values over the region's bytes: an 8-bit wrap-around sum, and a bitwise AND that starts at all ones. A region is good when its sum equals that region's own identification code. The four game regions are visited first, under codes 4, 3, 2 and 1 in that order. A utility region follows under code 0x80.

A start strobe launches a scan, and a count input says how many of the game regions, taken in scan order, must be present. A game region beyond that count may be an empty socket. Such a socket reads as all ones, so its AND result stays at 0xFF, and the block then skips the region. If the optional region does hold data, its sum is checked as usual. The utility region is always mandatory.

The scan stops at the first bad region. It then reports fail, with that region's code as the error code. A count of 0xFF is treated as a corrupt table and fails at once. Each start yields one single-cycle done pulse, along with pass and error-code outputs that stay held until the next accepted start.

Top module: `rom_chk_top`

## Requirements
- R1: Regions are `2**REGION_LOG2` bytes long (4096 by default). They are read at one address per cycle, in ascending order within a region. The region base is its slot number shifted left by `REGION_LOG2`. The visiting order is: code 4 in slot 1, code 3 in slot 2, code 2 in slot 12, code 1 in slot 3, and last the utility code 0x80 in slot 0.
- R2: A region that is checked passes only when the 8-bit modulo-256 sum of all its bytes equals its code.
- R3: A game region at scan position k (0 to 3) is optional when k >= `must_cnt`. An optional region whose bytes AND together to 0xFF is skipped as good, whatever its sum is.
- R4: A mandatory game region (k < `must_cnt`) and the utility region are never skipped as empty. An all-0xFF region of this kind fails unless its sum equals its code.
- R5: An optional region whose AND result is not 0xFF is checked against its code like a mandatory one.
- R6: A start with `must_cnt` equal to 0xFF gives `done`=1, `pass`=0 and `err_code`=0xFF in the cycle right after the start edge.
- R7: The scan stops at the first failing region, at scan position k. Then `done`=1, `pass`=0, and `err_code` is that region's code, visible (k+1)*(2**REGION_LOG2+1) cycles after the start edge.
- R8: When all five regions are good, `done`=1, `pass`=1 and `err_code`=0, visible 5*(2**REGION_LOG2+1) cycles after the start edge.
- R9: `done` is high for exactly one cycle per accepted start. `pass` and `err_code` hold their values until the next accepted start.
- R10: A `start` (with any `must_cnt`) arriving while a scan is in progress is ignored. The running scan's result and timing are unchanged.
- R11: After reset, `done`, `pass` and `err_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, honoured only while idle |
| must_cnt | input | 8 | Number of mandatory game regions; 0xFF means corrupt |
| mem_addr | output | REGION_LOG2+4 | Byte read address |
| mem_rdata | input | 8 | Read data, returned one cycle after its address |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Verdict of the last scan |
| err_code | output | 8 | Code of the failing region, 0xFF for a corrupt count, 0 on pass |

## Verification
Each region takes one cycle per byte to issue its reads, plus one more cycle while the final byte returns and is judged. The result of the region at scan position k is therefore due (k+1)*(N+1) cycles after the start edge. A corrupt count answers in the very next cycle. The bench derives the due cycle from its own model of the memory contents. It samples on falling edges while counting cycles from the start edge. It requires the single done pulse on exactly that cycle, and during every issue window it checks that the address equals the region base plus the in-region offset. A few cycles past the due point it confirms that no second pulse came and that the verdict was held.

// File: rtl/rom_chk_pkg.sv
package rom_chk_pkg;

  typedef logic [7:0] byte_t;

  localparam int NUM_REGIONS = 5;
  localparam int IDX_W       = 3;
  localparam logic [IDX_W-1:0] UTIL_IDX = IDX_W'(NUM_REGIONS - 1);

  // Identification code expected as the byte sum of each scan position.
  function automatic byte_t region_code(input logic [IDX_W-1:0] idx);
    byte_t c;
    case (idx)
      3'd0:    c = 8'h04;
      3'd1:    c = 8'h03;
      3'd2:    c = 8'h02;
      3'd3:    c = 8'h01;
      default: c = 8'h80;
    endcase
    return c;
  endfunction

  // Slot number (base address divided by region size) of each scan position.
  function automatic logic [3:0] region_slot(input logic [IDX_W-1:0] idx);
    logic [3:0] s;
    case (idx)
      3'd0:    s = 4'd1;
      3'd1:    s = 4'd2;
      3'd2:    s = 4'd12;
      3'd3:    s = 4'd3;
      default: s = 4'd0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/rom_chk_seq.sv
module rom_chk_seq
  import rom_chk_pkg::*;
#(
  parameter int REGION_LOG2 = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   launch,
  input  logic                   advance,
  output logic [REGION_LOG2+3:0] mem_addr,
  output logic                   rd_vld,
  output logic                   rd_last,
  output logic [IDX_W-1:0]       region_idx
);

  localparam logic [REGION_LOG2-1:0] OFF_LAST = '1;

  logic [REGION_LOG2-1:0] off_q;
  logic                   issuing_q;
  logic [IDX_W-1:0]       idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q     <= '0;
      issuing_q <= 1'b0;
      idx_q     <= '0;
      rd_vld    <= 1'b0;
      rd_last   <= 1'b0;
    end else begin
      rd_vld  <= issuing_q;
      rd_last <= issuing_q && (off_q == OFF_LAST);
      if (launch) begin
        idx_q     <= '0;
        off_q     <= '0;
        issuing_q <= 1'b1;
      end else if (advance) begin
        idx_q     <= idx_q + 1'b1;
        off_q     <= '0;
        issuing_q <= 1'b1;
      end else if (issuing_q) begin
        off_q <= off_q + 1'b1;
        if (off_q == OFF_LAST) issuing_q <= 1'b0;
      end
    end
  end

  assign mem_addr   = {region_slot(idx_q), off_q};
  assign region_idx = idx_q;

  // R1
  region_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(issuing_q) |-> (rd_last && rd_vld && off_q == '0));

  // R1
  last_has_vld_chk: assert property (@(posedge clk) disable iff (rst)
    rd_last |-> rd_vld);

endmodule

// File: rtl/rom_chk_accum.sv
module rom_chk_accum
  import rom_chk_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  rd_vld,
  input  logic  rd_last,
  input  byte_t mem_rdata,
  output byte_t sum_fin,
  output byte_t and_fin
);

  byte_t sum_q;
  byte_t and_q;

  assign sum_fin = sum_q + mem_rdata;
  assign and_fin = and_q & mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      and_q <= '1;
    end else if (rd_vld) begin
      if (rd_last) begin
        sum_q <= '0;
        and_q <= '1;
      end else begin
        sum_q <= sum_fin;
        and_q <= and_fin;
      end
    end
  end

  // R2
  acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_last |=> (sum_q == 8'h00 && and_q == 8'hFF));

endmodule

// File: rtl/rom_chk_judge.sv
module rom_chk_judge
  import rom_chk_pkg::*;
(
  input  logic [IDX_W-1:0] region_idx,
  input  byte_t            must_cnt,
  input  byte_t            sum_fin,
  input  byte_t            and_fin,
  output logic             region_ok,
  output byte_t            code
);

  logic mandatory;
  logic empty;

  always_comb begin
    code      = region_code(region_idx);
    mandatory = (region_idx == UTIL_IDX) || ({5'b0, region_idx} < must_cnt);
    empty     = (and_fin == 8'hFF);
    region_ok = (sum_fin == code) || (!mandatory && empty);
  end

endmodule

// File: rtl/rom_chk_top.sv
module rom_chk_top
  import rom_chk_pkg::*;
#(
  parameter int REGION_LOG2 = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [7:0]             must_cnt,
  output logic [REGION_LOG2+3:0] mem_addr,
  input  logic [7:0]             mem_rdata,
  output logic                   done,
  output logic                   pass,
  output logic [7:0]             err_code
);

  localparam byte_t BAD_CNT = 8'hFF;

  logic             busy_q;
  byte_t            cnt_q;
  logic             launch;
  logic             advance;
  logic             rd_vld;
  logic             rd_last;
  logic [IDX_W-1:0] region_idx;
  byte_t            sum_fin;
  byte_t            and_fin;
  logic             region_ok;
  byte_t            code;

  assign launch  = start && !busy_q && (must_cnt != BAD_CNT);
  assign advance = busy_q && rd_last && region_ok && (region_idx != UTIL_IDX);

  rom_chk_seq #(.REGION_LOG2(REGION_LOG2)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .launch     (launch),
    .advance    (advance),
    .mem_addr   (mem_addr),
    .rd_vld     (rd_vld),
    .rd_last    (rd_last),
    .region_idx (region_idx)
  );

  rom_chk_accum u_accum (
    .clk       (clk),
    .rst       (rst),
    .rd_vld    (rd_vld),
    .rd_last   (rd_last),
    .mem_rdata (mem_rdata),
    .sum_fin   (sum_fin),
    .and_fin   (and_fin)
  );

  rom_chk_judge u_judge (
    .region_idx (region_idx),
    .must_cnt   (cnt_q),
    .sum_fin    (sum_fin),
    .and_fin    (and_fin),
    .region_ok  (region_ok),
    .code       (code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      done     <= 1'b0;
      pass     <= 1'b0;
      err_code <= '0;
    end else begin
      done <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          pass     <= 1'b0;
          if (must_cnt == BAD_CNT) begin
            done     <= 1'b1;
            err_code <= BAD_CNT;
          end else begin
            busy_q   <= 1'b1;
            cnt_q    <= must_cnt;
            err_code <= '0;
          end
        end
      end else if (rd_last) begin
        if (!region_ok) begin
          busy_q   <= 1'b0;
          done     <= 1'b1;
          pass     <= 1'b0;
          err_code <= code;
        end else if (region_idx == UTIL_IDX) begin
          busy_q   <= 1'b0;
          done     <= 1'b1;
          pass     <= 1'b1;
          err_code <= '0;
        end
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  pass_code_chk: assert property (@(posedge clk) disable iff (rst)
    (done && pass) |-> (err_code == 8'h00));

  // R7
  fail_code_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !pass) |-> (err_code != 8'h00));

  // R10
  start_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> $stable(cnt_q));

endmodule

// File: tb/rom_chk_top_bench.sv
module rom_chk_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RL2        = 6;
  localparam int NB         = 1 << RL2;
  localparam int SPAN       = NB + 1;
  localparam int MEM_DEPTH  = 16 << RL2;
  localparam int WD_LIMIT   = 190000;

  localparam int K_GOOD  = 0;
  localparam int K_BAD   = 1;
  localparam int K_EMPTY = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [7:0]      must_cnt = 8'h00;
  logic [RL2+3:0]  mem_addr;
  logic [7:0]      mem_rdata;
  logic            done;
  logic            pass;
  logic [7:0]      err_code;

  logic [7:0] mem [MEM_DEPTH];

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) mem_rdata <= mem[mem_addr];

  rom_chk_top #(.REGION_LOG2(RL2)) u_rom_chk_top (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .must_cnt  (must_cnt),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .done      (done),
    .pass      (pass),
    .err_code  (err_code)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      n_checks++;
      n_fails++;
      $display("FAIL R9 watchdog: actual cycles %0d expected < %0d", cyc, WD_LIMIT);
      summary();
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Scan order per R1.
  function automatic int b_slot(input int k);
    case (k)
      0: return 1;
      1: return 2;
      2: return 12;
      3: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] b_code(input int k);
    case (k)
      0: return 8'h04;
      1: return 8'h03;
      2: return 8'h02;
      3: return 8'h01;
      default: return 8'h80;
    endcase
  endfunction

  task automatic fill_region(input int k, input int kind);
    int base = b_slot(k) << RL2;
    logic [7:0] s = 8'h00;
    for (int i = 0; i < NB; i++) begin
      if (kind == K_EMPTY) mem[base+i] = 8'hFF;
      else if (i < NB-1) begin
        mem[base+i] = 8'($urandom);
        s = s + mem[base+i];
      end else if (kind == K_GOOD) mem[base+i] = b_code(k) - s;
      else mem[base+i] = b_code(k) - s + 8'(1 + ($urandom % 255));
    end
  endtask

  task automatic fill_all(input int k0, input int k1, input int k2, input int k3, input int k4);
    fill_region(0, k0);
    fill_region(1, k1);
    fill_region(2, k2);
    fill_region(3, k3);
    fill_region(4, k4);
  endtask

  // Independent model of R2..R8.
  task automatic model(input logic [7:0] cnt, output bit ep, output logic [7:0] ee, output int el);
    if (cnt == 8'hFF) begin
      ep = 1'b0; ee = 8'hFF; el = 0;
      return;
    end
    for (int k = 0; k < 5; k++) begin
      int base = b_slot(k) << RL2;
      logic [7:0] s = 8'h00;
      logic [7:0] a = 8'hFF;
      bit must;
      for (int i = 0; i < NB; i++) begin
        s = s + mem[base+i];
        a = a & mem[base+i];
      end
      must = (k == 4) || (k < int'(cnt));
      if (!((s == b_code(k)) || (!must && a == 8'hFF))) begin
        ep = 1'b0; ee = b_code(k); el = (k+1)*SPAN;
        return;
      end
    end
    ep = 1'b1; ee = 8'h00; el = 5*SPAN;
  endtask

  task automatic run_case(input logic [7:0] cnt, input bit inject, input string tag);
    bit ep;
    logic [7:0] ee;
    int el;
    int nd = 0;
    int first_c = -1;
    int nreg;
    int addr_bad = 0;
    logic [31:0] bad_act = 0;
    logic [31:0] bad_exp = 0;
    logic got_pass = 1'b0;
    logic [7:0] got_err = 8'h00;
    model(cnt, ep, ee, el);
    nreg = el / SPAN;
    @(negedge clk);
    start    = 1'b1;
    must_cnt = cnt;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= el + 3; c++) begin
      int k = c / SPAN;
      int j = c % SPAN;
      if (c > 0) @(negedge clk);
      if (inject && c == 2) begin start = 1'b1; must_cnt = 8'hFF; end
      if (inject && c == 3) begin start = 1'b0; must_cnt = cnt; end
      if (k < nreg && j < NB) begin
        logic [31:0] ea = 32'((b_slot(k) << RL2) + j);
        if (32'(mem_addr) != ea) begin
          if (addr_bad == 0) begin bad_act = 32'(mem_addr); bad_exp = ea; end
          addr_bad++;
        end
      end
      if (done) begin
        nd++;
        if (first_c < 0) begin
          first_c = c;
          got_pass = pass;
          got_err = err_code;
        end
      end
    end
    check(addr_bad == 0, {tag, " R1 address order"}, bad_act, bad_exp);
    check(nd == 1, {tag, " R9 done pulse count"}, 32'(nd), 32'd1);
    check(first_c == el, {tag, " done latency"}, 32'(first_c), 32'(el));
    check(got_pass == ep, {tag, " pass"}, 32'(got_pass), 32'(ep));
    check(got_err == ee, {tag, " err_code"}, 32'(got_err), 32'(ee));
    check(pass == got_pass && err_code == got_err, {tag, " R9 verdict hold"},
          {23'd0, pass, err_code}, {23'd0, got_pass, got_err});
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < MEM_DEPTH; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && pass == 1'b0 && err_code == 8'h00, "R11 reset outputs",
          {23'd0, done, pass, err_code}, 32'd0);

    // R8: everything good
    fill_all(K_GOOD, K_GOOD, K_GOOD, K_GOOD, K_GOOD);
    run_case(8'd4, 1'b0, "R8");
    // R7: region code 2 bad, first failure stops the scan
    fill_all(K_GOOD, K_GOOD, K_BAD, K_GOOD, K_GOOD);
    run_case(8'd4, 1'b0, "R7");
    // R2: first region sum wrong while mandatory
    fill_all(K_BAD, K_GOOD, K_GOOD, K_GOOD, K_GOOD);
    run_case(8'd4, 1'b0, "R2");
    // R3: optional empty sockets skipped
    fill_all(K_GOOD, K_EMPTY, K_EMPTY, K_EMPTY, K_GOOD);
    run_case(8'd1, 1'b0, "R3");
    // R5: optional but populated region with bad sum fails
    fill_all(K_GOOD, K_GOOD, K_EMPTY, K_BAD, K_GOOD);
    run_case(8'd2, 1'b0, "R5");
    // R4: mandatory empty region fails
    fill_all(K_GOOD, K_EMPTY, K_GOOD, K_GOOD, K_GOOD);
    run_case(8'd4, 1'b0, "R4");
    // R4: utility region never treated as empty
    fill_all(K_EMPTY, K_EMPTY, K_EMPTY, K_EMPTY, K_EMPTY);
    run_case(8'd0, 1'b0, "R4 utility");
    // R6: corrupt count
    fill_all(K_GOOD, K_GOOD, K_GOOD, K_GOOD, K_GOOD);
    run_case(8'hFF, 1'b0, "R6");
    // R10: start with a corrupt count during a scan is ignored
    run_case(8'd4, 1'b1, "R10");

    // Random mixes, R2/R3/R4/R5 against the model
    for (int r = 0; r < 14; r++) begin
      int kinds[5];
      for (int k = 0; k < 5; k++) begin
        int p = $urandom % 10;
        kinds[k] = (p < 6) ? K_GOOD : (p < 8) ? K_EMPTY : K_BAD;
      end
      fill_all(kinds[0], kinds[1], kinds[2], kinds[3], kinds[4]);
      run_case(8'($urandom % 6), (r % 3) == 1, "R2 random");
    end

    summary();
  end

endmodule